// File: doc/BRIEF.md
# Multiplexed-Bus Byte-Lane Bridge

This block sits on the target side of a 16-bit host bus that carries address and data on the same lines, and connects that bus to an 8-bit peripheral port. The host puts the address on the shared lines in two phases, upper half first, each closed by a rising edge of the address-valid strobe. The bridge latches both halves and keeps them for the whole chip-select window. Several data transfers may follow in that window. Every host strobe passes through a two-flop synchronizer, and an edge detector follows it. A strobe edge therefore takes effect at the third rising clock edge after it arrives.

On a write, the active-low byte enables pick the lane and the address parity. A 16-bit write is split into two peripheral writes, and a wait output is raised while the split runs. On a read, the host drives both enables low whatever the access size, so the enables are not used to pick the lane. The lane comes from a separate A0 line. In the alternative shifted mode, A0 and the lane are both ignored and the peripheral sees the host word address. The fetched byte is copied onto both halves of the data lines.

The controller has nine states:
- `S_IDLE` moves to `S_ADDR_HI` when chip select is asserted.
- `S_ADDR_HI` moves to `S_ADDR_LO`, and `S_ADDR_LO` moves to `S_DATA`, each on a rising edge of address valid.
- `S_DATA` moves to `S_RD_REQ` when output enable falls, or to `S_WR_FIRST` when write enable falls with at least one byte enabled.
- The read path runs `S_RD_REQ`, then `S_RD_CAP`, then `S_RD_DRIVE`. `S_RD_DRIVE` returns to `S_DATA` when output enable rises.
- `S_WR_FIRST` moves to `S_WR_SECOND` on a split write, otherwise back to `S_DATA`. `S_WR_SECOND` always returns to `S_DATA`.
- `S_ADDR_HI`, `S_ADDR_LO`, `S_DATA` and `S_RD_DRIVE` return to `S_IDLE` when chip select is released.

Top module: `mux_byte_bridge`

## Requirements
- R1: While reset is held, `ad_oe`, `wait_o`, `per_we` and `per_re` are all 0.
- R2: The first rising edge of `adv_n` after chip select latches `ad_in` as the upper address half. The second latches the lower half. Together they form the word address W = {upper, lower}, which holds until `cs_n` goes high. In normal mode (`shift_mode`=0) the peripheral address is {W[PA_W-2:0], lane}.
- R3: On a write in normal mode, `be_n`=2'b10 (bit 0 is the low-lane enable, bit 1 the high-lane enable, both active low) writes `ad_in[7:0]` with lane 0. `be_n`=2'b01 writes `ad_in[15:8]` with lane 1.
- R4: In normal mode a write with `be_n`=2'b00 produces two peripheral write cycles back to back. The first writes `ad_in[7:0]` with lane 0 and the second writes `ad_in[15:8]` with lane 1. `wait_o` is 1 during both cycles and 0 in the cycle after.
- R5: A write with `be_n`=2'b11 produces no peripheral write.
- R6: On a read in normal mode, the lane is taken from `a0` and the byte enables have no effect on the read address.
- R7: In shifted mode (`shift_mode`=1), the peripheral address is W[PA_W-1:0] for both reads and writes, and `a0` is ignored. A write with `be_n`=2'b00 writes only `ad_in[7:0]`, as one cycle, with `wait_o` at 0.
- R8: On a read, the fetched byte appears on both `ad_out[15:8]` and `ad_out[7:0]`.
- R9: `ad_oe` is 1 only during a read data phase while chip select and output enable are both asserted. It is 0 during writes and after output enable is released.
- R10: A read issues a single-cycle `per_re`, and `wait_o` is 1 from that cycle until the byte is loaded.
- R11: A falling edge of `oe_n` or `we_n` has no effect on the outputs before the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_mode | input | 1 | 1 selects the shifted-address mode |
| cs_n | input | 1 | Host chip select, active low |
| adv_n | input | 1 | Host address-valid strobe, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| be_n | input | 2 | Host byte enables, active low; bit 0 is the low lane |
| a0 | input | 1 | Separate host byte-address bit |
| ad_in | input | BUS_W | Shared address/data lines as seen by the bridge |
| ad_out | output | BUS_W | Value driven onto the shared lines |
| ad_oe | output | 1 | 1 when the bridge drives the shared lines |
| wait_o | output | 1 | Busy indication to the host |
| per_addr | output | PA_W | Peripheral byte address |
| per_wdata | output | 8 | Peripheral write byte |
| per_we | output | 1 | Peripheral write strobe, one cycle per byte |
| per_re | output | 1 | Peripheral read request, one cycle |
| per_rdata | input | 8 | Peripheral read byte, valid the cycle after `per_re` |

## Verification
Counts below are rising clock edges after a host strobe changes.
- Write:
  - At the second edge `per_we` must still be 0.
  - At the third edge the first write strobe is out, with its address and byte.
  - At the fourth edge the second half of a split write is out.
  - After the fifth edge `wait_o` is 0.
- Read:
  - At the third edge `per_re`, `wait_o` and `ad_oe` are 1.
  - At the fourth edge `per_re` is 0.
  - The duplicated byte and the release of `wait_o` follow the fifth edge.

The bench changes stimulus on falling clock edges and counts rising edges with a tick task. It samples on the falling edge after the edge in question, so each check lands in the exact cycle its result is due.

// File: rtl/mux_byte_bridge_pkg.sv
package mux_byte_bridge_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_HI,
        S_ADDR_LO,
        S_DATA,
        S_RD_REQ,
        S_RD_CAP,
        S_RD_DRIVE,
        S_WR_FIRST,
        S_WR_SECOND
    } bridge_state_t;

    // positions inside the synchronized strobe vector
    localparam int SIG_CS  = 0;
    localparam int SIG_ADV = 1;
    localparam int SIG_OE  = 2;
    localparam int SIG_WE  = 3;
    localparam int SIG_BE0 = 4;
    localparam int SIG_BE1 = 5;
    localparam int SIG_A0  = 6;
    localparam int SIG_N   = 7;

    // idle level of every synchronized input
    localparam logic [SIG_N-1:0] SIG_IDLE = 7'b011_1111;

endpackage

// File: rtl/mux_byte_bridge_sync.sv
module mux_byte_bridge_sync #(
    parameter int WIDTH = 7,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else begin
                    if (s == 0) begin
                        chain[s] <= async_in;
                    end else begin
                        chain[s] <= chain[(s == 0) ? 0 : s-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= RST_VAL;
        end else begin
            prev <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/mux_byte_bridge_addr.sv
module mux_byte_bridge_addr #(
    parameter int BUS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   ad_in,
    input  logic               cap_hi,
    input  logic               cap_lo,
    output logic [2*BUS_W-1:0] word_addr
);
    logic [BUS_W-1:0] hi_q;
    logic [BUS_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_hi) hi_q <= ad_in;
            if (cap_lo) lo_q <= ad_in;
        end
    end

    assign word_addr = {hi_q, lo_q};
endmodule

// File: rtl/mux_byte_bridge_fsm.sv
module mux_byte_bridge_fsm
    import mux_byte_bridge_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int PA_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_mode,
    input  logic             cs_s,
    input  logic             oe_s,
    input  logic             adv_rise,
    input  logic             oe_fall,
    input  logic             we_fall,
    input  logic [1:0]       be_s,
    input  logic             a0_s,
    input  logic [BUS_W-1:0] ad_in,
    input  logic [PA_W-1:0]  word_addr,
    input  logic [7:0]       per_rdata,
    output logic             cap_hi,
    output logic             cap_lo,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    output logic             wait_o,
    output logic [PA_W-1:0]  per_addr,
    output logic [7:0]       per_wdata,
    output logic             per_we,
    output logic             per_re
);
    localparam int BYTE_W = BUS_W / 2;

    bridge_state_t state, nxt;
    logic [BUS_W-1:0]  wr_data;
    logic [1:0]        wr_be;
    logic              rd_lane;
    logic [BYTE_W-1:0] rd_buf;
    logic              split;
    logic              wr_hi_lane;
    logic              lane;

    assign split      = !shift_mode && (wr_be == 2'b00);
    assign wr_hi_lane = (wr_be == 2'b01);

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (!cs_s) nxt = S_ADDR_HI;
            S_ADDR_HI:   if (cs_s) nxt = S_IDLE; else if (adv_rise) nxt = S_ADDR_LO;
            S_ADDR_LO:   if (cs_s) nxt = S_IDLE; else if (adv_rise) nxt = S_DATA;
            S_DATA: begin
                if (cs_s) nxt = S_IDLE;
                else if (oe_fall) nxt = S_RD_REQ;
                else if (we_fall && (be_s != 2'b11)) nxt = S_WR_FIRST;
            end
            S_RD_REQ:    nxt = S_RD_CAP;
            S_RD_CAP:    nxt = S_RD_DRIVE;
            S_RD_DRIVE:  if (cs_s) nxt = S_IDLE; else if (oe_s) nxt = S_DATA;
            S_WR_FIRST:  nxt = split ? S_WR_SECOND : S_DATA;
            S_WR_SECOND: nxt = S_DATA;
            default:     nxt = S_IDLE;
        endcase
    end

    // state register and the data held across states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wr_data <= '0;
            wr_be   <= 2'b11;
            rd_lane <= 1'b0;
            rd_buf  <= '0;
        end else begin
            state <= nxt;
            if (state == S_DATA && we_fall) begin
                wr_data <= ad_in;
                wr_be   <= be_s;
            end
            if (state == S_DATA && oe_fall) begin
                rd_lane <= a0_s;
            end
            if (state == S_RD_CAP) begin
                rd_buf <= per_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        cap_hi = (state == S_ADDR_HI) && adv_rise && !cs_s;
        cap_lo = (state == S_ADDR_LO) && adv_rise && !cs_s;

        unique case (state)
            S_RD_REQ, S_RD_CAP: lane = rd_lane;
            S_WR_SECOND:        lane = 1'b1;
            default:            lane = wr_hi_lane;
        endcase

        if (shift_mode) per_addr = word_addr;
        else            per_addr = {word_addr[PA_W-2:0], lane};

        if (lane) per_wdata = wr_data[BUS_W-1:BYTE_W];
        else      per_wdata = wr_data[BYTE_W-1:0];

        per_we = (state == S_WR_FIRST) || (state == S_WR_SECOND);
        per_re = (state == S_RD_REQ);
        wait_o = (state == S_RD_REQ) || (state == S_RD_CAP) ||
                 (state == S_WR_SECOND) || ((state == S_WR_FIRST) && split);
        ad_oe  = !cs_s && !oe_s &&
                 ((state == S_RD_REQ) || (state == S_RD_CAP) || (state == S_RD_DRIVE));
        ad_out = {rd_buf, rd_buf};
    end
endmodule

// File: rtl/mux_byte_bridge.sv
module mux_byte_bridge
    import mux_byte_bridge_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int PA_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_mode,
    input  logic             cs_n,
    input  logic             adv_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [1:0]       be_n,
    input  logic             a0,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    output logic             wait_o,
    output logic [PA_W-1:0]  per_addr,
    output logic [7:0]       per_wdata,
    output logic             per_we,
    output logic             per_re,
    input  logic [7:0]       per_rdata
);
    localparam int WA_W = 2 * BUS_W;

    logic [SIG_N-1:0] raw, lvl, rise, fall;
    logic [WA_W-1:0]  word_full;
    logic             cap_hi, cap_lo;
    logic             unused_sync;

    assign raw = {a0, be_n[1], be_n[0], we_n, oe_n, adv_n, cs_n};

    mux_byte_bridge_sync #(
        .WIDTH(SIG_N), .STAGES(2), .RST_VAL(SIG_IDLE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    mux_byte_bridge_addr #(.BUS_W(BUS_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in),
        .cap_hi(cap_hi), .cap_lo(cap_lo), .word_addr(word_full)
    );

    generate
        if (PA_W < WA_W) begin : g_trim
            logic unused_addr;
            assign unused_addr = ^word_full[WA_W-1:PA_W];
        end
    endgenerate

    assign unused_sync = ^{lvl[SIG_ADV], lvl[SIG_WE], rise[SIG_CS], rise[SIG_OE],
                           rise[SIG_WE], rise[SIG_A0:SIG_BE0], fall[SIG_CS],
                           fall[SIG_ADV], fall[SIG_A0:SIG_BE0]};

    mux_byte_bridge_fsm #(.BUS_W(BUS_W), .PA_W(PA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .shift_mode(shift_mode),
        .cs_s(lvl[SIG_CS]), .oe_s(lvl[SIG_OE]),
        .adv_rise(rise[SIG_ADV]), .oe_fall(fall[SIG_OE]), .we_fall(fall[SIG_WE]),
        .be_s(lvl[SIG_BE1:SIG_BE0]), .a0_s(lvl[SIG_A0]),
        .ad_in(ad_in), .word_addr(word_full[PA_W-1:0]), .per_rdata(per_rdata),
        .cap_hi(cap_hi), .cap_lo(cap_lo),
        .ad_out(ad_out), .ad_oe(ad_oe), .wait_o(wait_o),
        .per_addr(per_addr), .per_wdata(per_wdata),
        .per_we(per_we), .per_re(per_re)
    );
endmodule

// File: rtl/mux_byte_bridge_chk.sv
module mux_byte_bridge_chk #(
    parameter int BUS_W = 16,
    parameter int PA_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             oe_n,
    input logic             shift_mode,
    input logic [BUS_W-1:0] ad_out,
    input logic             ad_oe,
    input logic             wait_o,
    input logic [PA_W-1:0]  per_addr,
    input logic             per_we,
    input logic             per_re
);
    // R9
    drive_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!$past(oe_n, 2) && !$past(cs_n, 2)));

    // R10
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_re |=> !per_re);

    // R10
    read_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_re |-> wait_o);

    // R4
    split_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(per_we) && wait_o && !shift_mode) |-> (per_addr[0] == 1'b0));

    // R4
    split_high_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(per_we) && wait_o && !shift_mode) |=> (per_we && per_addr[0] && wait_o));

    // R7
    shift_no_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_we && shift_mode) |-> !wait_o);

    // R8
    lanes_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !wait_o) |-> (ad_out[BUS_W-1:BUS_W/2] == ad_out[BUS_W/2-1:0]));
endmodule

bind mux_byte_bridge mux_byte_bridge_chk #(.BUS_W(BUS_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/mux_byte_bridge_test.sv
`timescale 1ns/1ps
module mux_byte_bridge_test;
    localparam int PA_W = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_mode = 1'b0;
    logic        cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [1:0]  be_n = 2'b11;
    logic        a0 = 1'b0;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe, wait_o, per_we, per_re;
    logic [PA_W-1:0] per_addr;
    logic [7:0]  per_wdata;
    logic [7:0]  per_rdata = '0;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    bit done = 0;
    logic [31:0] cur_w;

    logic [7:0] pmem    [logic [PA_W-1:0]];
    logic [7:0] exp_mem [logic [PA_W-1:0]];

    always #2 clk = ~clk;

    mux_byte_bridge #(.BUS_W(16), .PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n), .shift_mode(shift_mode),
        .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
        .be_n(be_n), .a0(a0), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .wait_o(wait_o),
        .per_addr(per_addr), .per_wdata(per_wdata),
        .per_we(per_we), .per_re(per_re), .per_rdata(per_rdata)
    );

    function automatic logic [7:0] dflt(input logic [PA_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] pm_rd(input logic [PA_W-1:0] a);
        if (pmem.exists(a)) return pmem[a];
        return dflt(a);
    endfunction

    function automatic logic [7:0] ex_rd(input logic [PA_W-1:0] a);
        if (exp_mem.exists(a)) return exp_mem[a];
        return dflt(a);
    endfunction

    // peripheral model: one-cycle registered read, write at the edge
    always @(posedge clk) begin
        if (per_we) begin
            pmem[per_addr] = per_wdata;
            we_cnt = we_cnt + 1;
        end
        if (per_re) per_rdata <= pm_rd(per_addr);
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [15:0] hi, input logic [15:0] lo);
        cur_w = {hi, lo};
        cs_n = 1'b0;
        tick(3);
        ad_in = hi; adv_n = 1'b0;
        tick(2);
        adv_n = 1'b1;
        tick(4);
        ad_in = lo; adv_n = 1'b0;
        tick(2);
        adv_n = 1'b1;
        tick(4);
    endtask

    task automatic end_cycle();
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        tick(5);
        check("R9 idle lines", {31'd0, ad_oe}, 32'd0);
    endtask

    task automatic do_write(input logic [1:0] be, input logic [15:0] d);
        int c0;
        logic lane, split;
        logic [PA_W-1:0] a1, a2;
        logic [7:0] b1;
        lane  = (be == 2'b01);
        split = !shift_mode && (be == 2'b00);
        a1 = shift_mode ? cur_w[PA_W-1:0] : {cur_w[PA_W-2:0], lane};
        a2 = {cur_w[PA_W-2:0], 1'b1};
        b1 = lane ? d[15:8] : d[7:0];
        be_n = be; ad_in = d;
        tick(2);
        c0 = we_cnt;
        we_n = 1'b0;
        tick(2);
        check("R11 no write before third edge", {31'd0, per_we}, 32'd0);
        tick(1);
        check("R9 no drive during write", {31'd0, ad_oe}, 32'd0);
        if (be == 2'b11) begin
            check("R5 no write strobe", {31'd0, per_we}, 32'd0);
        end else begin
            check(shift_mode ? "R7 write strobe" : "R3 write strobe", {31'd0, per_we}, 32'd1);
            check(shift_mode ? "R7 write address" : "R2 write address", {12'd0, per_addr}, {12'd0, a1});
            check(shift_mode ? "R7 write byte" : "R3 write byte", {24'd0, per_wdata}, {24'd0, b1});
        end
        tick(1);
        check("R4 second strobe", {31'd0, per_we}, {31'd0, split});
        check("R4 wait during split", {31'd0, wait_o}, {31'd0, split});
        if (split) begin
            check("R4 second address", {12'd0, per_addr}, {12'd0, a2});
            check("R4 second byte", {24'd0, per_wdata}, {24'd0, d[15:8]});
        end
        tick(1);
        check("R4 wait released", {31'd0, wait_o}, 32'd0);
        check("R4 strobes done", {31'd0, per_we}, 32'd0);
        if (be != 2'b11) exp_mem[a1] = b1;
        if (split) exp_mem[a2] = d[15:8];
        tick(2);
        we_n = 1'b1;
        tick(4);
        check((be == 2'b11) ? "R5 write count" : "R4 write count", we_cnt - c0,
              (be == 2'b11) ? 0 : (split ? 2 : 1));
        if (be != 2'b11) check("R3 stored byte", {24'd0, pm_rd(a1)}, {24'd0, ex_rd(a1)});
    endtask

    task automatic do_read(input logic a0v, input logic [1:0] be);
        logic [PA_W-1:0] ra;
        logic [7:0] b;
        ra = shift_mode ? cur_w[PA_W-1:0] : {cur_w[PA_W-2:0], a0v};
        b  = ex_rd(ra);
        a0 = a0v; be_n = be;
        tick(3);
        oe_n = 1'b0;
        tick(2);
        check("R11 no read before third edge", {30'd0, per_re, ad_oe}, 32'd0);
        tick(1);
        check("R10 read request", {31'd0, per_re}, 32'd1);
        check("R10 wait on request", {31'd0, wait_o}, 32'd1);
        check("R9 drive in read", {31'd0, ad_oe}, 32'd1);
        check(shift_mode ? "R7 read address" : "R6 read address", {12'd0, per_addr}, {12'd0, ra});
        tick(1);
        check("R10 request single cycle", {31'd0, per_re}, 32'd0);
        check("R10 wait while loading", {31'd0, wait_o}, 32'd1);
        tick(1);
        check("R10 wait released", {31'd0, wait_o}, 32'd0);
        check("R8 duplicated byte", {16'd0, ad_out}, {16'd0, b, b});
        oe_n = 1'b1;
        tick(3);
        check("R9 released after read", {31'd0, ad_oe}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R1 reset drive", {31'd0, ad_oe}, 32'd0);
        check("R1 reset wait", {31'd0, wait_o}, 32'd0);
        check("R1 reset strobes", {30'd0, per_we, per_re}, 32'd0);
        rst_n = 1'b1;
        tick(3);
        for (int m = 0; m < 2; m++) begin
            shift_mode = m[0];
            tick(2);
            for (int k = 0; k < 6; k++) begin
                addr_phase(16'(k * 3 + 1), 16'(k * 16'h2345 + 16'h0102));
                for (int be = 0; be < 4; be++) begin
                    do_write(be[1:0], {8'(k * 17 + be * 5 + m), 8'(k * 29 + be * 3 + 7 * m + 1)});
                end
                for (int a = 0; a < 2; a++) begin
                    do_read(a[0], 2'b00);
                    do_read(a[0], 2'b01);
                end
                end_cycle();
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule